// File: doc/BRIEF.md
# Position-Scheduled Pulse Output Channel

This block drives one digital output line from a short schedule of encoder positions. Each schedule slot holds a trigger position, a pulse length in clock ticks and an end-of-list marker. The schedule sits in a small external memory that this block reads through a synchronous read port. An upstream agent loads the schedule, then pulses `start` to say the whole pass is ready. From then on the block steps through the slots in index order.

For each slot with a nonzero length, the block waits until the live encoder count reaches the slot's position. What "reached" means depends on the direction of travel. It then holds the output high for exactly the stored number of ticks. Slots with a zero length are skipped. The travel direction is captured when the pass starts. When the final slot has been handled, the block signals completion for one cycle and goes back to waiting for the next start.

Top module: `enc_pulse_sched`

## Requirements
- R1: After synchronous reset, `trig_out`, `pass_done` and `rd_en` are low and the block is idle, waiting for `start`.
- R2: A `start` pulse while idle begins a pass at slot 0. A `start` pulse while a pass is running has no effect: exactly one `pass_done` results.
- R3: Each slot is fetched by one `rd_en` cycle carrying `rd_addr`. Memory data is taken one cycle later. The first fetch occurs in the cycle right after the edge that sampled `start`.
- R4: With `dir_neg` = 0 at start, a slot is reached when `enc_count >= position`. `trig_out` rises on the clock edge that samples the match, so with a unit-step ramp it rises on the edge where `enc_count` equals the position.
- R5: With `dir_neg` = 1 at start, a slot is reached when `enc_count <= position`, and the output rises the same way as in R4.
- R6: A slot with length N (N >= 1) keeps `trig_out` high for exactly N consecutive cycles.
- R7: A slot with length 0 produces no pulse. The block moves on to the next slot, or ends the pass if the slot is the final one.
- R8: `dir_neg` is sampled only when a pass starts. Changing it during a pass has no effect on the comparisons.
- R9: If the next slot's position has already been passed when a pulse ends, the next pulse starts after exactly three low cycles. Pulses are never merged.
- R10: A pass ends after a slot with `rd_last` = 1, or after slot DEPTH-1. `pass_done` is then high for one cycle, in the first low cycle after the final pulse, and the block returns to idle.
- R11: Positions and encoder counts are compared as signed two's-complement values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pass start strobe; the schedule is fully loaded |
| dir_neg | input | 1 | Travel direction: 0 = counting up, 1 = counting down |
| enc_count | input | POS_W | Live signed encoder count |
| rd_en | output | 1 | Schedule memory read strobe |
| rd_addr | output | AW | Schedule slot index being read |
| rd_pos | input | POS_W | Signed trigger position, valid one cycle after `rd_en` |
| rd_dur | input | DUR_W | Pulse length in ticks, valid one cycle after `rd_en` |
| rd_last | input | 1 | End-of-list marker, valid one cycle after `rd_en` |
| trig_out | output | 1 | Registered trigger output |
| pass_done | output | 1 | One-cycle pass completion flag |

## Verification
The channel is driven with unit-step encoder ramps, both up and down, against several schedules. A mixed schedule with a skipped slot and an early end marker separates correct slot stepping from off-by-one indexing. A full table with no marker shows that the pass ends on the index limit. A pair of closely spaced positions exposes any merging of pulses, or any wrong gap between them. A sweep of pulse lengths in both directions pins down the tick count. Signed positions below zero, including one that is already passed when the pass starts, expose unsigned comparison. Toggling the direction input and re-pulsing `start` mid-pass must leave the pulse pattern unchanged.

// File: rtl/enc_pulse_sched.sv
module enc_pulse_sched #(
  parameter int POS_W = 32,
  parameter int DUR_W = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    dir_neg,
  input  logic signed [POS_W-1:0] enc_count,
  output logic                    rd_en,
  output logic [AW-1:0]           rd_addr,
  input  logic signed [POS_W-1:0] rd_pos,
  input  logic [DUR_W-1:0]        rd_dur,
  input  logic                    rd_last,
  output logic                    trig_out,
  output logic                    pass_done
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_ARM, S_PULSE, S_DONE} state_t;

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  state_t                    state;
  logic [AW-1:0]             idx;
  logic signed [POS_W-1:0]   pos_q;
  logic [DUR_W-1:0]          dur_q, cnt;
  logic                      last_q, dir_q, trig_q;

  wire hit       = dir_q ? (enc_count <= pos_q) : (enc_count >= pos_q);
  wire end_entry = last_q || (idx == LAST_IDX);

  assign rd_en     = (state == S_FETCH);
  assign rd_addr   = idx;
  assign trig_out  = trig_q;
  assign pass_done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx    <= '0;
      pos_q  <= '0;
      dur_q  <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
      dir_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx   <= '0;
          dir_q <= dir_neg;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          pos_q  <= rd_pos;
          dur_q  <= rd_dur;
          last_q <= rd_last;
          if (rd_dur == '0) begin
            if (rd_last || idx == LAST_IDX) state <= S_DONE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            state <= S_ARM;
          end
        end
        S_ARM: if (hit) begin
          trig_q <= 1'b1;
          cnt    <= dur_q;
          state  <= S_PULSE;
        end
        S_PULSE: begin
          if (cnt == DUR_W'(1)) begin
            trig_q <= 1'b0;
            if (end_entry) state <= S_DONE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [DUR_W-1:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)           hi_len <= '0;
    else if (trig_out) hi_len <= hi_len + 1'b1;
    else               hi_len <= '0;
  end

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(trig_out) |-> hi_len == dur_q);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done && !trig_out);

  // R4
  rise_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> $past(hit));

  // R7
  zero_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && rd_dur == '0) |=> !trig_out);

  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(dir_q));

  // R3
  no_read_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> !rd_en);

endmodule

// File: tb/enc_pulse_sched_tb.sv
module enc_pulse_sched_tb_top;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, dir_neg, rd_en, rd_last, trig_out, pass_done;
  logic signed [31:0] enc_count, rd_pos;
  logic [15:0] rd_dur;
  logic [2:0] rd_addr;

  int mem_pos [DEPTH];
  int mem_dur [DEPTH];
  bit mem_last[DEPTH];

  always_ff @(posedge clk) if (rd_en) begin
    rd_pos  <= mem_pos[rd_addr];
    rd_dur  <= 16'(mem_dur[rd_addr]);
    rd_last <= mem_last[rd_addr];
  end

  enc_pulse_sched #(.POS_W(32), .DUR_W(16), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir_neg(dir_neg), .enc_count(enc_count),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_pos(rd_pos), .rd_dur(rd_dur),
    .rd_last(rd_last), .trig_out(trig_out), .pass_done(pass_done));

  int checks = 0, fails = 0;
  int np, nd, nreads, first_rd, done_c, last_fall_c;
  int rise_enc[16];
  int plen[16];
  int gap[16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) begin
      mem_pos[i] = 0; mem_dur[i] = 0; mem_last[i] = 0;
    end
  endtask

  task automatic run_pass(input bit dneg, input int e0, input int step, input int maxc,
                          input bit flip_dir, input bit extra_start);
    int enc, hi, lo;
    bit prev;
    np = 0; nd = 0; nreads = 0; first_rd = -1; done_c = -1; last_fall_c = -1;
    hi = 0; lo = 0; prev = 0; enc = e0;
    @(negedge clk);
    enc_count = enc; dir_neg = dneg; start = 1'b1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (rd_en) begin
        nreads++;
        if (first_rd < 0) first_rd = c;
      end
      if (trig_out && !prev) begin
        rise_enc[np] = enc; gap[np] = lo; hi = 0;
      end
      if (trig_out) hi++;
      if (!trig_out && prev) begin
        plen[np] = hi; np++; lo = 0; last_fall_c = c;
      end
      if (!trig_out) lo++;
      if (pass_done) begin nd++; done_c = c; end
      prev = trig_out;
      start = (extra_start && c == 20) ? 1'b1 : 1'b0;
      if (flip_dir && c == 10) dir_neg = ~dneg;
      enc = enc + step;
      enc_count = enc;
    end
    dir_neg = 1'b0; start = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; dir_neg = 1'b0; enc_count = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!trig_out, "R1 trig", trig_out, 0);
    chk(!pass_done, "R1 done", pass_done, 0);
    chk(!rd_en, "R1 rd_en", rd_en, 0);

    // mixed schedule, positive: skipped slot, end marker before slot 4
    clear_mem();
    mem_pos[0] = 20; mem_dur[0] = 3;
    mem_pos[1] = 30; mem_dur[1] = 0;
    mem_pos[2] = 40; mem_dur[2] = 5;
    mem_pos[3] = 60; mem_dur[3] = 1; mem_last[3] = 1;
    mem_pos[4] = 70; mem_dur[4] = 4;
    run_pass(0, 0, 1, 100, 0, 0);
    chk(np == 3, "R7 pulse count", np, 3);
    chk(rise_enc[0] == 20, "R4 rise 0", rise_enc[0], 20);
    chk(rise_enc[1] == 40, "R4 rise 1", rise_enc[1], 40);
    chk(rise_enc[2] == 60, "R4 rise 2", rise_enc[2], 60);
    chk(plen[0] == 3, "R6 len 0", plen[0], 3);
    chk(plen[1] == 5, "R6 len 1", plen[1], 5);
    chk(plen[2] == 1, "R6 len 2", plen[2], 1);
    chk(nd == 1, "R10 done count", nd, 1);
    chk(done_c == last_fall_c, "R10 done timing", done_c, last_fall_c);
    chk(nreads == 4, "R3 read count", nreads, 4);
    chk(first_rd == 0, "R3 first read", first_rd, 0);

    // negative direction; direction flipped and start re-pulsed mid-pass
    clear_mem();
    mem_pos[0] = 80; mem_dur[0] = 2;
    mem_pos[1] = 50; mem_dur[1] = 4;
    mem_pos[2] = 30; mem_dur[2] = 3; mem_last[2] = 1;
    run_pass(1, 100, -1, 100, 1, 1);
    chk(np == 3, "R5 pulse count", np, 3);
    chk(rise_enc[0] == 80, "R5 rise 0", rise_enc[0], 80);
    chk(rise_enc[1] == 50, "R8 rise 1", rise_enc[1], 50);
    chk(rise_enc[2] == 30, "R8 rise 2", rise_enc[2], 30);
    chk(nd == 1, "R2 busy start ignored", nd, 1);

    // back-to-back: second position passed during first pulse
    clear_mem();
    mem_pos[0] = 10; mem_dur[0] = 6;
    mem_pos[1] = 11; mem_dur[1] = 2; mem_last[1] = 1;
    run_pass(0, 0, 1, 40, 0, 0);
    chk(np == 2, "R9 pulse count", np, 2);
    chk(plen[0] == 6, "R9 len 0", plen[0], 6);
    chk(gap[1] == 3, "R9 gap", gap[1], 3);
    chk(plen[1] == 2, "R9 len 1", plen[1], 2);

    // full table, no marker: ends on index limit
    clear_mem();
    for (int k = 0; k < DEPTH; k++) begin
      mem_pos[k] = 10 * k + 5; mem_dur[k] = k + 1;
    end
    run_pass(0, 0, 1, 120, 0, 0);
    chk(np == DEPTH, "R10 full count", np, DEPTH);
    chk(nd == 1, "R10 full done", nd, 1);
    chk(nreads == DEPTH, "R3 full reads", nreads, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      chk(rise_enc[k] == 10 * k + 5, "R4 full rise", rise_enc[k], 10 * k + 5);
      chk(plen[k] == k + 1, "R6 full len", plen[k], k + 1);
    end

    // all zero lengths, marker at slot 3
    clear_mem();
    mem_pos[0] = 3; mem_pos[1] = 4; mem_pos[2] = 5; mem_pos[3] = 6; mem_last[3] = 1;
    mem_dur[4] = 5;
    run_pass(0, 0, 1, 30, 0, 0);
    chk(np == 0, "R7 no pulse", np, 0);
    chk(nd == 1, "R7 done", nd, 1);
    chk(done_c == 8, "R7 done timing", done_c, 8);
    chk(nreads == 4, "R7 reads", nreads, 4);

    // length sweep, both directions
    for (int d = 1; d <= 6; d++) begin
      for (int dn = 0; dn < 2; dn++) begin
        clear_mem();
        mem_pos[0] = 5; mem_dur[0] = d; mem_last[0] = 1;
        run_pass(dn[0], dn ? 15 : 0, dn ? -1 : 1, 25, 0, 0);
        chk(np == 1, "R6 sweep count", np, 1);
        chk(plen[0] == d, "R6 sweep len", plen[0], d);
        chk(rise_enc[0] == 5, dn ? "R5 sweep rise" : "R4 sweep rise", rise_enc[0], 5);
        chk(nd == 1, "R10 sweep done", nd, 1);
      end
    end

    // signed positions
    clear_mem();
    mem_pos[0] = -5; mem_dur[0] = 2; mem_last[0] = 1;
    run_pass(0, -20, 1, 30, 0, 0);
    chk(np == 1 && rise_enc[0] == -5, "R11 pos dir", rise_enc[0], -5);
    run_pass(1, 10, -1, 30, 0, 0);
    chk(np == 1 && rise_enc[0] == -5, "R11 neg dir", rise_enc[0], -5);
    run_pass(0, 100, 1, 20, 0, 0);
    chk(np == 1 && rise_enc[0] == 103, "R11 already passed", rise_enc[0], 103);

    repeat (3) @(negedge clk);
    chk(!trig_out && !pass_done && !rd_en, "R10 idle after", trig_out, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule